// File: doc/BRIEF.md
# Flat Access Dispatch Slot Arbiter

This block sits between wave selection and the execute stage of a compute unit. Each execution unit owns one dispatch slot, and every cycle the selection logic offers at most one wave per slot. The arbiter settles the final state of every slot. A flat memory access offered on a global-memory slot also needs the local-memory pipe that belongs to its wave, so the arbiter takes that local slot, marks it skip and writes the flat wave's id into it. Any wave already waiting in that local slot is sent back to its schedule queue.

After flat arbitration, each execute-ready slot must be granted write ports on the register files for its destination operands. A slot that is refused goes back to its queue and becomes empty. If the refused slot holds a flat access, its paired local slot is also emptied. The arbiter then counts the execution units that the surviving slots reserve. A unit reserved twice, or a skip slot that does not match a live flat access, sets a sticky error flag. All results are registered, so they appear one cycle after the offer, and every slot starts empty again in the next cycle.

The slot layout comes from package parameters. Slots are numbered with the ALU slots first, then the global-memory slots, then the local-memory slots. With the defaults this gives ALU slots 0 to 3, global slots 4 and 5, and local slots 6 and 7.

Top module: `flat_slot_arbiter`

## Requirements
- R1: While reset is held and in the cycle after it is released, every slot reads EMPTY, no reinsert or bus-stall strobe is high and `errSticky` is low. Reset is the only way to clear `errSticky`.
- R2: Slot state is encoded as 0 = EMPTY, 1 = execute-ready, 2 = SKIP. Take a slot that is offered a wave, is not involved in flat arbitration and is granted its write ports. One cycle after the offer it reads execute-ready and `slotWave` carries the offered wave id. A slot offered nothing reads EMPTY in the next cycle.
- R3: Global slot g (default slot 4 + g) is offered a flat access whose local index is k, and the access is granted its write ports. One cycle later slot g reads execute-ready and local slot k (default slot 6 + k) reads SKIP, with `slotWave` equal to the wave id of slot g.
- R4: A different wave offered on a local slot that a flat access claims is reinserted. Its `reinsertReq` and `busStall` bits are high for one cycle, and `reinsertWave` carries its wave id.
- R5: A scalar instruction (`selScalar` = 1) needs only its scalar-file write grant. A vector instruction needs both the vector-file and the scalar-file grants. An execute-ready slot that lacks a grant it needs is reinserted and reads EMPTY.
- R6: A flat access refused its write ports releases its local slot too: that slot reads EMPTY. A wave that was bounced from that local slot stays reinserted and is not restored.
- R7: The flat flag has no effect on ALU or local-memory slots. Such a slot behaves exactly like a non-flat slot.
- R8: `errSticky` rises when two flat accesses claim the same local slot in one cycle, and it stays high until reset.
- R9: The local index picks the local slot. Default global slot 5 with local index 1 claims slot 7, and slot 6 is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| selReady | input | SLOTS | Per slot: a selected wave is offered |
| selWave | input | SLOTS x WAVE_W | Per slot: wave id of the offered wave |
| selFlat | input | SLOTS | Per slot: the offered instruction is a flat access |
| selScalar | input | SLOTS | Per slot: the offered instruction is scalar |
| selLocal | input | GM_SLOTS x LM_IDX_W | Per global slot: index of the wave's local-memory slot |
| vrfWrOk | input | SLOTS | Per slot: vector-file write ports granted |
| srfWrOk | input | SLOTS | Per slot: scalar-file write ports granted |
| slotState | output | SLOTS x 2 | Registered final state of each slot |
| slotWave | output | SLOTS x WAVE_W | Wave id held by each slot (0 when empty) |
| reinsertReq | output | SLOTS | Wave of this slot goes back to its schedule queue |
| reinsertWave | output | SLOTS x WAVE_W | Wave id being reinserted (0 when none) |
| busStall | output | SLOTS | Reinsert caused by losing the local bus to a flat access |
| errSticky | output | 1 | Sticky reservation or skip-pairing error |

## Verification
The bench aims at the orderings that are easy to get wrong. One is a flat access that bounces a local-slot wave and is then refused its own write ports. A design that restored the bounced wave would leave that slot live, and one that forgot the pairing would leave a dangling SKIP. The bench also checks the write-grant rule for scalar and vector instructions separately: a design that checked the vector grant for everything would wrongly refuse scalar work. Other targets are a flat flag on a non-global slot, which must not steal a local slot, and the local index choosing the correct local slot. Finally, a double claim must raise the error, the error must survive idle cycles and only reset may clear it.

// File: rtl/flat_arb_pkg.sv
package flat_arb_pkg;
  parameter int ALU_SLOTS = 4;
  parameter int GM_SLOTS  = 2;
  parameter int LM_SLOTS  = 2;
  parameter int WAVE_W    = 6;

  localparam int SLOTS      = ALU_SLOTS + GM_SLOTS + LM_SLOTS;
  localparam int GM_BASE    = ALU_SLOTS;
  localparam int LM_BASE    = ALU_SLOTS + GM_SLOTS;
  localparam int SLOT_IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LM_IDX_W   = (LM_SLOTS > 1) ? $clog2(LM_SLOTS) : 1;
  localparam int GM_IDX_W   = (GM_SLOTS > 1) ? $clog2(GM_SLOTS) : 1;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_GO    = 2'd1,
    SLOT_SKIP  = 2'd2
  } slotState_e;

  typedef struct packed {
    slotState_e [SLOTS-1:0]                  state;
    logic [SLOTS-1:0]                        reinsert;
    logic [SLOTS-1:0]                        busStall;
    logic [LM_SLOTS-1:0][GM_IDX_W-1:0]       owner;
    logic                                    conflict;
    logic                                    pairBad;
  } strobes_t;
endpackage

// File: rtl/flat_arb_ctrl.sv
module flat_arb_ctrl
  import flat_arb_pkg::*;
(
  input  logic [SLOTS-1:0]                   selReady,
  input  logic [SLOTS-1:0]                   selFlat,
  input  logic [SLOTS-1:0]                   selScalar,
  input  logic [GM_SLOTS-1:0][LM_IDX_W-1:0]  selLocal,
  input  logic [SLOTS-1:0]                   vrfWrOk,
  input  logic [SLOTS-1:0]                   srfWrOk,
  output strobes_t                           strobes
);
  logic [SLOTS-1:0] writeOk;
  logic [SLOTS-1:0] unitUsed;
  logic [SLOT_IDX_W-1:0] lIdx;
  logic [GM_IDX_W-1:0] gOwn;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      writeOk[i] = srfWrOk[i] && (selScalar[i] || vrfWrOk[i]);
    end
  end

  always_comb begin
    strobes  = '0;
    unitUsed = '0;
    lIdx     = '0;
    gOwn     = '0;
    for (int i = 0; i < SLOTS; i++) begin
      strobes.state[i] = selReady[i] ? SLOT_GO : SLOT_EMPTY;
    end

    // flat arbitration: global slots in ascending order
    for (int g = 0; g < GM_SLOTS; g++) begin
      if (selReady[GM_BASE+g] && selFlat[GM_BASE+g] &&
          (int'(selLocal[g]) < LM_SLOTS)) begin
        lIdx = SLOT_IDX_W'(LM_BASE) + SLOT_IDX_W'(selLocal[g]);
        if (strobes.state[lIdx] == SLOT_GO) begin
          strobes.reinsert[lIdx] = 1'b1;
          strobes.busStall[lIdx] = 1'b1;
        end
        strobes.state[lIdx] = SLOT_SKIP;
        strobes.owner[selLocal[g]] = GM_IDX_W'(g);
      end
    end

    // destination write-port check
    for (int i = 0; i < SLOTS; i++) begin
      if (strobes.state[i] == SLOT_GO && !writeOk[i]) begin
        strobes.reinsert[i] = 1'b1;
        strobes.state[i]    = SLOT_EMPTY;
        if (i >= GM_BASE && i < LM_BASE && selFlat[i] &&
            (int'(selLocal[i-GM_BASE]) < LM_SLOTS)) begin
          lIdx = SLOT_IDX_W'(LM_BASE) + SLOT_IDX_W'(selLocal[i-GM_BASE]);
          if (strobes.state[lIdx] == SLOT_SKIP &&
              strobes.owner[selLocal[i-GM_BASE]] == GM_IDX_W'(i - GM_BASE)) begin
            strobes.state[lIdx] = SLOT_EMPTY;
          end
        end
      end
    end

    // execution unit reservation
    for (int i = 0; i < SLOTS; i++) begin
      if (strobes.state[i] == SLOT_GO) begin
        if (unitUsed[i]) strobes.conflict = 1'b1;
        unitUsed[i] = 1'b1;
        if (i >= GM_BASE && i < LM_BASE && selFlat[i] &&
            (int'(selLocal[i-GM_BASE]) < LM_SLOTS)) begin
          lIdx = SLOT_IDX_W'(LM_BASE) + SLOT_IDX_W'(selLocal[i-GM_BASE]);
          if (unitUsed[lIdx]) strobes.conflict = 1'b1;
          unitUsed[lIdx] = 1'b1;
        end
      end
    end

    // skip pairing consistency
    for (int k = 0; k < LM_SLOTS; k++) begin
      if (strobes.state[LM_BASE+k] == SLOT_SKIP) begin
        gOwn = strobes.owner[k];
        if (!(strobes.state[GM_BASE+int'(gOwn)] == SLOT_GO &&
              selFlat[GM_BASE+int'(gOwn)] &&
              int'(selLocal[gOwn]) == k)) begin
          strobes.pairBad = 1'b1;
        end
      end
    end
    for (int g = 0; g < GM_SLOTS; g++) begin
      if (strobes.state[GM_BASE+g] == SLOT_GO && selFlat[GM_BASE+g] &&
          (int'(selLocal[g]) < LM_SLOTS)) begin
        lIdx = SLOT_IDX_W'(LM_BASE) + SLOT_IDX_W'(selLocal[g]);
        if (strobes.state[lIdx] != SLOT_SKIP ||
            strobes.owner[selLocal[g]] != GM_IDX_W'(g)) begin
          strobes.pairBad = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flat_arb_dpath.sv
module flat_arb_dpath
  import flat_arb_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  strobes_t                         strobes,
  input  logic [SLOTS-1:0]                 selReady,
  input  logic [SLOTS-1:0][WAVE_W-1:0]     selWave,
  output logic [SLOTS-1:0][1:0]            stateQ,
  output logic [SLOTS-1:0][WAVE_W-1:0]     waveQ,
  output logic [SLOTS-1:0]                 reinQ,
  output logic [SLOTS-1:0][WAVE_W-1:0]     reinWaveQ,
  output logic [SLOTS-1:0]                 stallQ,
  output logic                             errQ
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [WAVE_W-1:0] waveNext;
    if (i >= LM_BASE) begin : g_local
      always_comb begin
        case (strobes.state[i])
          SLOT_GO:   waveNext = selWave[i];
          SLOT_SKIP: waveNext = selWave[GM_BASE + int'(strobes.owner[i-LM_BASE])];
          default:   waveNext = '0;
        endcase
      end
    end else begin : g_plain
      always_comb begin
        waveNext = (strobes.state[i] == SLOT_GO) ? selWave[i] : '0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stateQ[i]    <= SLOT_EMPTY;
        waveQ[i]     <= '0;
        reinQ[i]     <= 1'b0;
        reinWaveQ[i] <= '0;
        stallQ[i]    <= 1'b0;
      end else begin
        stateQ[i]    <= strobes.state[i];
        waveQ[i]     <= waveNext;
        reinQ[i]     <= strobes.reinsert[i];
        reinWaveQ[i] <= strobes.reinsert[i] ? selWave[i] : '0;
        stallQ[i]    <= strobes.busStall[i];
      end
    end

    p_bounce_not_live_r4: assert property (@(posedge clk) disable iff (rst)
      stallQ[i] |-> (reinQ[i] && stateQ[i] != SLOT_GO));

    p_reinsert_had_wave_r5: assert property (@(posedge clk) disable iff (rst)
      reinQ[i] |-> $past(selReady[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else     errQ <= errQ | strobes.conflict | strobes.pairBad;
  end

  // every skip slot mirrors a live global slot carrying the same wave
  logic [LM_SLOTS-1:0] skipMatched;
  always_comb begin
    skipMatched = '0;
    for (int k = 0; k < LM_SLOTS; k++) begin
      for (int g = 0; g < GM_SLOTS; g++) begin
        if (stateQ[GM_BASE+g] == SLOT_GO && waveQ[GM_BASE+g] == waveQ[LM_BASE+k])
          skipMatched[k] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LM_SLOTS; k++) begin : g_skipchk
    p_skip_paired_r3: assert property (@(posedge clk) disable iff (rst)
      (!errQ && stateQ[LM_BASE+k] == SLOT_SKIP) |-> skipMatched[k]);
  end

  p_err_holds_r8: assert property (@(posedge clk) disable iff (rst)
    errQ |=> errQ);

  p_clean_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (stateQ == '0 && reinQ == '0 && stallQ == '0 && !errQ));
endmodule

// File: rtl/flat_slot_arbiter.sv
module flat_slot_arbiter
  import flat_arb_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst,
  input  logic [SLOTS-1:0]                   selReady,
  input  logic [SLOTS-1:0][WAVE_W-1:0]       selWave,
  input  logic [SLOTS-1:0]                   selFlat,
  input  logic [SLOTS-1:0]                   selScalar,
  input  logic [GM_SLOTS-1:0][LM_IDX_W-1:0]  selLocal,
  input  logic [SLOTS-1:0]                   vrfWrOk,
  input  logic [SLOTS-1:0]                   srfWrOk,
  output logic [SLOTS-1:0][1:0]              slotState,
  output logic [SLOTS-1:0][WAVE_W-1:0]       slotWave,
  output logic [SLOTS-1:0]                   reinsertReq,
  output logic [SLOTS-1:0][WAVE_W-1:0]       reinsertWave,
  output logic [SLOTS-1:0]                   busStall,
  output logic                               errSticky
);
  strobes_t strobes;

  flat_arb_ctrl u_ctrl (
    .selReady (selReady),
    .selFlat  (selFlat),
    .selScalar(selScalar),
    .selLocal (selLocal),
    .vrfWrOk  (vrfWrOk),
    .srfWrOk  (srfWrOk),
    .strobes  (strobes)
  );

  flat_arb_dpath u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .selReady (selReady),
    .selWave  (selWave),
    .stateQ   (slotState),
    .waveQ    (slotWave),
    .reinQ    (reinsertReq),
    .reinWaveQ(reinsertWave),
    .stallQ   (busStall),
    .errQ     (errSticky)
  );
endmodule

// File: tb/sim_flat_slot_arbiter.sv
module sim_flat_slot_arbiter;
  import flat_arb_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SLOTS-1:0] selReady = '0, selFlat = '0, selScalar = '0;
  logic [SLOTS-1:0] vrfWrOk = '1, srfWrOk = '1;
  logic [SLOTS-1:0][WAVE_W-1:0] selWave;
  logic [GM_SLOTS-1:0][LM_IDX_W-1:0] selLocal = '0;
  logic [SLOTS-1:0][1:0] slotState;
  logic [SLOTS-1:0][WAVE_W-1:0] slotWave, reinsertWave;
  logic [SLOTS-1:0] reinsertReq, busStall;
  logic errSticky;

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flat_slot_arbiter u0 (
    .clk(clk), .rst(rst), .selReady(selReady), .selWave(selWave),
    .selFlat(selFlat), .selScalar(selScalar), .selLocal(selLocal),
    .vrfWrOk(vrfWrOk), .srfWrOk(srfWrOk), .slotState(slotState),
    .slotWave(slotWave), .reinsertReq(reinsertReq),
    .reinsertWave(reinsertWave), .busStall(busStall), .errSticky(errSticky)
  );

  // wave id of slot i is 20 + i
  always_comb begin
    for (int i = 0; i < SLOTS; i++) selWave[i] = WAVE_W'(20 + i);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic step(logic [7:0] rdy, logic [7:0] fl, logic [7:0] sc,
                      logic [7:0] vr, logic [7:0] sr, logic [1:0] loc);
    selReady  = rdy;
    selFlat   = fl;
    selScalar = sc;
    vrfWrOk   = vr;
    srfWrOk   = sr;
    selLocal  = loc;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  rdy, fl, sc, vr, sr;
    logic [1:0]  loc;
    logic [15:0] st;
    logic [7:0]  rein, stall;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h0F, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00, 16'h0055, 8'h00, 8'h00, 4'd2}, // R2
    '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00, 16'h0000, 8'h00, 8'h00, 4'd2}, // R2
    '{8'h10, 8'h10, 8'h00, 8'hFF, 8'hFF, 2'b00, 16'h2100, 8'h00, 8'h00, 4'd3}, // R3
    '{8'h10, 8'h10, 8'h00, 8'hFF, 8'hFF, 2'b01, 16'h8100, 8'h00, 8'h00, 4'd9}, // R9
    '{8'hA0, 8'h20, 8'h00, 8'hFF, 8'hFF, 2'b10, 16'h8400, 8'h80, 8'h80, 4'd4}, // R4
    '{8'h03, 8'h00, 8'h01, 8'h00, 8'hFF, 2'b00, 16'h0001, 8'h02, 8'h00, 4'd5}, // R5
    '{8'h01, 8'h00, 8'h01, 8'hFF, 8'hFE, 2'b00, 16'h0000, 8'h01, 8'h00, 4'd5}, // R5
    '{8'h50, 8'h10, 8'h00, 8'hEF, 8'hFF, 2'b00, 16'h0000, 8'h50, 8'h40, 4'd6}, // R6
    '{8'h42, 8'h42, 8'h00, 8'hFF, 8'hFF, 2'b00, 16'h1004, 8'h00, 8'h00, 4'd7}, // R7
    '{8'h30, 8'h30, 8'h00, 8'hFF, 8'hFF, 2'b10, 16'hA500, 8'h00, 8'h00, 4'd3}, // R3
    '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00, 16'h5555, 8'h00, 8'h00, 4'd2}, // R2
    '{8'h04, 8'h00, 8'h00, 8'hFF, 8'hFB, 2'b00, 16'h0000, 8'h04, 8'h00, 4'd5}  // R5
  };

  initial begin
    string tag;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "state in reset", 32'(slotState), 32'h0);
    chk("R1", "reinsert in reset", 32'(reinsertReq), 32'h0);
    chk("R1", "error in reset", 32'(errSticky), 32'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].rdy, VECS[v].fl, VECS[v].sc, VECS[v].vr, VECS[v].sr, VECS[v].loc);
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      chk(tag, "state", 32'(slotState), 32'(VECS[v].st));
      chk(tag, "reinsert", 32'(reinsertReq), 32'(VECS[v].rein));
      chk(tag, "busStall", 32'(busStall), 32'(VECS[v].stall));
      chk(tag, "error quiet (R8)", 32'(errSticky), 32'h0);
    end

    // R2: wave id carried on an execute-ready slot
    step(8'h01, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00);
    chk("R2", "wave slot0", 32'(slotWave[0]), 32'd20);
    chk("R2", "empty slot wave", 32'(slotWave[1]), 32'd0);

    // R3: skip slot holds the flat wave id
    step(8'h10, 8'h10, 8'h00, 8'hFF, 8'hFF, 2'b00);
    chk("R3", "skip wave slot6", 32'(slotWave[6]), 32'd24);

    // R4: bounced wave id reported, claimed slot carries flat wave
    step(8'hA0, 8'h20, 8'h00, 8'hFF, 8'hFF, 2'b10);
    chk("R4", "reinsert wave slot7", 32'(reinsertWave[7]), 32'd27);
    chk("R4", "skip wave slot7", 32'(slotWave[7]), 32'd25);
    chk("R9", "slot6 untouched", 32'(slotState[6]), 32'd0);

    // R8: double claim of one local slot raises the error
    step(8'h30, 8'h30, 8'h00, 8'hFF, 8'hFF, 2'b00);
    chk("R8", "error on double claim", 32'(errSticky), 32'h1);
    step(8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00);
    step(8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00);
    chk("R8", "error held while idle", 32'(errSticky), 32'h1);

    // R1: reset clears the error
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "error cleared by reset", 32'(errSticky), 32'h0);
    chk("R1", "state after reset", 32'(slotState), 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule